// File: doc/BRIEF.md
# Decrement-Only Counter Bank with Tear-Safe Commit

This block holds two 32-bit counters inside a small block-addressed memory space. The counters can only move downward. A host issues block writes through a plain request port made of an address, a 32-bit data word and a one-cycle strobe. A write to either counter address names the full new value. The write is taken only when that value is strictly below the stored one, so one write can lower a counter by any step. A counter that has reached zero stays at zero for good.

An accepted write runs a programming cycle of fixed length. During that cycle the candidate value waits in a shadow register and `busy` is high. The counter takes the candidate only when the cycle ends, and only if the power-fail input stayed low for the whole cycle. A failed cycle leaves the old value in place, so a partly written value is never visible. Each counter write ends with a one-cycle status pulse: accepted, rejected or aborted.

The upper 11 bits of the second counter form a reload count. An accepted write that changes this field arms an erase mode for the resettable one-time-programmable region at block addresses 0 to 4. While the mode is armed, each write to that region produces an erase indication. A select command or a power-off disarms it.

Top module: `decr_counter_bank`

## Requirements
- R1: After reset, `count_a` is 32'hFFFF_FFFE, `count_b` is 32'hFFFF_FFFF, and `busy`, `erase_armed` and all pulse outputs are 0.
- R2: A strobed write to an address other than 5 or 6 leaves both counters unchanged and does not raise `busy`.
- R3: A write to address 5 (`count_a`) or 6 (`count_b`) whose data is strictly below the stored value is accepted, whatever the step size. At the end of its programming cycle the counter holds exactly that data.
- R4: A counter write with data equal to or above the stored value is rejected. `ack_rej` pulses in the cycle after the strobe, `busy` stays low and the counter keeps its value. A counter at zero therefore never changes again.
- R5: If `pwr_fail` is high at the strobe or in any cycle of the programming cycle, the counter keeps its previous value and `ack_abort` pulses when the cycle ends.
- R6: `busy` is high for exactly PROG_CYCLES (default 8) consecutive cycles, starting in the cycle after an accepted strobe. The new value and the status pulse appear in the cycle after `busy` falls. Strobes that arrive while `busy` is high are ignored.
- R7: Every counter write that is not ignored produces exactly one one-cycle pulse on exactly one of `ack_ok`, `ack_rej` and `ack_abort`. A counter value never changes except together with `ack_ok`.
- R8: `erase_armed` rises when a committed write to address 6 changes bits 31:21 of `count_b`. A commit that changes only bits 20:0 leaves the flag as it was.
- R9: `erase_armed` is cleared by `sel_cmd` or `pwr_fail`. If a commit that sets the flag happens at the same clock edge as `sel_cmd`, the set takes priority.
- R10: A strobed write to an address from 0 to 4 while `erase_armed` is high and `busy` is low pulses `otp_erase` in the next cycle. Without the flag, no pulse appears.
- R11: `reload_left` always equals bits 31:21 of `count_b`, so the field can record at most 2047 reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle block-write strobe |
| wr_addr | input | ADDR_W (4) | Block address of the write |
| wr_data | input | DATA_W (32) | New block value |
| pwr_fail | input | 1 | Power-loss indication |
| sel_cmd | input | 1 | Select command seen, clears erase mode |
| count_a | output | DATA_W | Counter at address 5 |
| count_b | output | DATA_W | Counter at address 6 |
| reload_left | output | 11 | Reload field of `count_b` |
| busy | output | 1 | Programming cycle in progress |
| ack_ok | output | 1 | Write committed (pulse) |
| ack_rej | output | 1 | Write refused, value not lower (pulse) |
| ack_abort | output | 1 | Write lost to power fail (pulse) |
| erase_armed | output | 1 | Erase mode for OTP region armed |
| otp_erase | output | 1 | Current OTP write carries an erase (pulse) |

## Verification
The bench checks equal and higher values, which a comparator that allows equality would accept and so commit a no-op or an increase. It sends writes to a counter that is already at zero, which must stay terminal. It drops `pwr_fail` in the middle of a programming cycle, where a design that commits early or samples the fail only at the end would expose the new value. It also sends strobes while `busy` is high, which a careless design would take as fresh writes. Commits to address 6 that change only the low bits must not arm the erase mode. Select and power-fail must disarm it, and with the flag clear, writes to addresses 0 to 4 must not raise `otp_erase`.

// File: rtl/decr_counter_bank.sv
module decr_counter_bank #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 32,
  parameter int RELOAD_W    = 11,
  parameter int PROG_CYCLES = 8,
  parameter int A_ADDR      = 5,
  parameter int B_ADDR      = 6,
  parameter int OTP_TOP     = 4,
  parameter logic [DATA_W-1:0] A_INIT = 32'hFFFF_FFFE,
  parameter logic [DATA_W-1:0] B_INIT = 32'hFFFF_FFFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                pwr_fail,
  input  logic                sel_cmd,
  output logic [DATA_W-1:0]   count_a,
  output logic [DATA_W-1:0]   count_b,
  output logic [RELOAD_W-1:0] reload_left,
  output logic                busy,
  output logic                ack_ok,
  output logic                ack_rej,
  output logic                ack_abort,
  output logic                erase_armed,
  output logic                otp_erase
);
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1);
  localparam int RELOAD_LSB = DATA_W - RELOAD_W;

  logic [CNT_W-1:0]  left_q;
  logic              fail_q;
  logic              tgt_b_q;
  logic [DATA_W-1:0] shadow_q;

  wire hit_a    = (wr_addr == ADDR_W'(A_ADDR));
  wire hit_b    = (wr_addr == ADDR_W'(B_ADDR));
  wire hit_otp  = (wr_addr <= ADDR_W'(OTP_TOP));
  wire take     = wr_en && !busy;
  wire [DATA_W-1:0] cur = hit_a ? count_a : count_b;
  wire lower    = wr_data < cur;
  wire finish   = busy && (left_q == CNT_W'(1));
  wire lost     = fail_q || pwr_fail;
  wire commit   = finish && !lost;
  wire commit_b = commit && tgt_b_q;
  wire top_moved = shadow_q[DATA_W-1:RELOAD_LSB] != count_b[DATA_W-1:RELOAD_LSB];

  assign reload_left = count_b[DATA_W-1:RELOAD_LSB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_a   <= A_INIT;
      count_b   <= B_INIT;
      busy      <= 1'b0;
      left_q    <= '0;
      fail_q    <= 1'b0;
      tgt_b_q   <= 1'b0;
      shadow_q  <= '0;
      ack_ok    <= 1'b0;
      ack_rej   <= 1'b0;
      ack_abort <= 1'b0;
      otp_erase <= 1'b0;
    end else begin
      ack_ok    <= 1'b0;
      ack_rej   <= 1'b0;
      ack_abort <= 1'b0;
      otp_erase <= 1'b0;
      if (busy) begin
        fail_q <= lost;
        left_q <= left_q - CNT_W'(1);
        if (finish) begin
          busy <= 1'b0;
          if (lost) begin
            ack_abort <= 1'b1;
          end else begin
            ack_ok <= 1'b1;
            if (tgt_b_q) count_b <= shadow_q;
            else         count_a <= shadow_q;
          end
        end
      end else if (take) begin
        if (hit_a || hit_b) begin
          if (lower) begin
            busy     <= 1'b1;
            left_q   <= CNT_W'(PROG_CYCLES);
            fail_q   <= pwr_fail;
            tgt_b_q  <= hit_b;
            shadow_q <= wr_data;
          end else begin
            ack_rej <= 1'b1;
          end
        end else if (hit_otp && erase_armed) begin
          otp_erase <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   erase_armed <= 1'b0;
    else if (commit_b && top_moved) erase_armed <= 1'b1;
    else if (pwr_fail || sel_cmd) erase_armed <= 1'b0;
  end

  assert_a_down_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count_a) |-> count_a < $past(count_a));
  assert_b_down_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(count_b) |-> count_b < $past(count_b));
  assert_zero_terminal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(count_a) == '0) |-> (count_a == '0));
  assert_abort_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_abort |-> ($stable(count_a) && $stable(count_b)));
  assert_busy_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (ack_ok || ack_abort));
  assert_one_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_ok, ack_rej, ack_abort}));
  assert_change_needs_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(count_a) || !$stable(count_b)) |-> ack_ok);
  assert_arm_on_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_armed) |-> (ack_ok && !$stable(reload_left)));
  assert_otp_needs_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    otp_erase |-> $past(erase_armed));
endmodule

// File: tb/decr_counter_bank_tb.sv
module decr_counter_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        pwr_fail = 1'b0;
  logic        sel_cmd = 1'b0;
  logic [31:0] count_a, count_b;
  logic [10:0] reload_left;
  logic        busy, ack_ok, ack_rej, ack_abort, erase_armed, otp_erase;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  decr_counter_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwr_fail(pwr_fail), .sel_cmd(sel_cmd), .count_a(count_a), .count_b(count_b),
    .reload_left(reload_left), .busy(busy), .ack_ok(ack_ok), .ack_rej(ack_rej),
    .ack_abort(ack_abort), .erase_armed(erase_armed), .otp_erase(otp_erase)
  );

  // behavioural reference
  logic [31:0] e_a, e_b, m_val;
  logic        e_busy, e_ok, e_rej, e_ab, e_armed, e_otp, m_fail, m_tgt_b, arm_now;
  int          m_left;

  always @(posedge clk) begin
    if (!rst_n) begin
      e_a = 32'hFFFF_FFFE; e_b = 32'hFFFF_FFFF;
      e_busy = 0; e_ok = 0; e_rej = 0; e_ab = 0; e_armed = 0; e_otp = 0;
      m_left = 0; m_fail = 0; m_tgt_b = 0; m_val = 0;
    end else begin
      e_ok = 0; e_rej = 0; e_ab = 0; e_otp = 0; arm_now = 0;
      if (e_busy) begin
        m_fail = m_fail | pwr_fail;
        m_left = m_left - 1;
        if (m_left == 0) begin
          e_busy = 0;
          if (m_fail) e_ab = 1;
          else begin
            e_ok = 1;
            if (m_tgt_b) begin
              arm_now = (m_val[31:21] != e_b[31:21]);
              e_b = m_val;
            end else e_a = m_val;
          end
        end
      end else if (wr_en) begin
        if (wr_addr == 5 || wr_addr == 6) begin
          if (wr_data < ((wr_addr == 5) ? e_a : e_b)) begin
            e_busy = 1; m_left = 8; m_fail = pwr_fail; m_val = wr_data;
            m_tgt_b = (wr_addr == 6);
          end else e_rej = 1;
        end else if (wr_addr <= 4 && e_armed) e_otp = 1;
      end
      if (arm_now) e_armed = 1;
      else if (pwr_fail || sel_cmd) e_armed = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(count_a == e_a, "R3 count_a", count_a, e_a);
      chk(count_b == e_b, "R3 count_b", count_b, e_b);
      chk(busy == e_busy, "R6 busy", 32'(busy), 32'(e_busy));
      chk({ack_ok, ack_rej, ack_abort} == {e_ok, e_rej, e_ab}, "R7 status",
          32'({ack_ok, ack_rej, ack_abort}), 32'({e_ok, e_rej, e_ab}));
      chk(erase_armed == e_armed, "R8 erase_armed", 32'(erase_armed), 32'(e_armed));
      chk(otp_erase == e_otp, "R10 otp_erase", 32'(otp_erase), 32'(e_otp));
      chk(reload_left == e_b[31:21], "R11 reload_left", 32'(reload_left), 32'(e_b[31:21]));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
    repeat (11) @(posedge clk);
    #1;
  endtask

  task automatic pulse_sel(input bit pf);
    @(posedge clk); #1;
    if (pf) pwr_fail = 1; else sel_cmd = 1;
    @(posedge clk); #1;
    pwr_fail = 0; sel_cmd = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(count_a == 32'hFFFF_FFFE, "R1 reset count_a", count_a, 32'hFFFF_FFFE);
    chk(count_b == 32'hFFFF_FFFF, "R1 reset count_b", count_b, 32'hFFFF_FFFF);
    chk({busy, erase_armed, ack_ok, ack_rej, ack_abort, otp_erase} == 0, "R1 reset flags",
        32'({busy, erase_armed, ack_ok, ack_rej, ack_abort, otp_erase}), 0);

    wr(5, 32'hFFFF_FFFD);
    wr(5, 32'hFFFF_FFF5);
    wr(5, 32'hFFFF_FFF5);
    chk(count_a == 32'hFFFF_FFF5, "R4 equal rejected", count_a, 32'hFFFF_FFF5);
    wr(5, 32'hFFFF_FFFF);
    chk(count_a == 32'hFFFF_FFF5, "R4 higher rejected", count_a, 32'hFFFF_FFF5);
    wr(7, 32'h0);
    chk(count_a == 32'hFFFF_FFF5 && count_b == 32'hFFFF_FFFF, "R2 other address",
        count_a ^ count_b, 32'hFFFF_FFF5 ^ 32'hFFFF_FFFF);
    wr(2, 32'h1234);
    wr(6, 32'hFFFF_FFF0);
    chk(erase_armed == 0, "R8 low bits only", 32'(erase_armed), 0);
    wr(6, 32'hFFDF_FFFF);
    chk(erase_armed == 1, "R8 top bits change", 32'(erase_armed), 1);
    wr(3, 32'h55);
    pulse_sel(0);
    chk(erase_armed == 0, "R9 select clears", 32'(erase_armed), 0);
    wr(1, 32'h66);
    wr(6, 32'hFF9F_FFFF);
    pulse_sel(1);
    chk(erase_armed == 0, "R9 power-off clears", 32'(erase_armed), 0);

    // power fail during programming
    @(posedge clk); #1;
    wr_en = 1; wr_addr = 5; wr_data = 32'h1000;
    @(posedge clk); #1 wr_en = 0;
    repeat (3) @(posedge clk);
    #1 pwr_fail = 1;
    @(posedge clk); #1 pwr_fail = 0;
    repeat (8) @(posedge clk);
    #1;
    chk(count_a == 32'hFFFF_FFF5, "R5 abort keeps value", count_a, 32'hFFFF_FFF5);

    // strobe while busy is ignored
    @(posedge clk); #1;
    wr_en = 1; wr_addr = 5; wr_data = 32'd100;
    @(posedge clk); #1 wr_en = 0;
    @(posedge clk); #1;
    wr_en = 1; wr_data = 32'd50;
    @(posedge clk); #1 wr_en = 0;
    repeat (9) @(posedge clk);
    #1;
    chk(count_a == 32'd100, "R6 busy strobe ignored", count_a, 32'd100);

    wr(5, 32'h0);
    wr(5, 32'h0);
    chk(count_a == 32'h0, "R4 zero terminal", count_a, 32'h0);

    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1;
      wr_en = ($urandom_range(0, 2) != 0);
      wr_addr = 4'($urandom_range(0, 7));
      case ($urandom_range(0, 3))
        0: wr_data = $urandom;
        1: wr_data = e_b - 32'($urandom_range(0, 3));
        2: wr_data = e_b - 32'h0020_0000;
        default: wr_data = e_a;
      endcase
      pwr_fail = ($urandom_range(0, 30) == 0);
      sel_cmd  = ($urandom_range(0, 20) == 0);
    end
    @(posedge clk); #1;
    wr_en = 0; pwr_fail = 0; sel_cmd = 0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule